// File: doc/BRIEF.md
# Dual-Polarity Run Detector

This block watches one serial bit stream and drives one flag bit that is normally high. The flag falls low in the same cycle that the bit on the input completes a run of four zeros or a run of three ones. The output is a Mealy output: it is formed from the registered state and the live input bit, so a detection shows up without waiting for the next clock edge.

Runs are tracked one polarity at a time. A bit of the other value discards the run in progress and opens a run of length one for the new value. Once a run has been detected the machine returns to its start state, so none of the bits in that run count toward the next one. A sample-enable strobe qualifies each input bit. Cycles without the strobe leave the tracking untouched. A synchronous active-high reset returns the machine to its start state. The registered state is brought out on a small debug port.

Top module: `run_flag_fsm`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes start (`state_o` = 0), and `flag_o` is 1 in every cycle where `rst` is high.
- R2: `flag_o` is 1 in every cycle that does not complete a qualifying run, including streams that alternate or are shorter than the thresholds.
- R3: When `smp_en` is 1 and `din` is 0 in the cycle that is the fourth consecutive sampled zero, `flag_o` is 0 during that cycle.
- R4: When `smp_en` is 1 and `din` is 1 in the cycle that is the third consecutive sampled one, `flag_o` is 0 during that cycle.
- R5: After a detection the next state is start, so a steady zero stream flags on its 4th, 8th, 12th ... sample and a steady one stream flags on its 3rd, 6th ... sample.
- R6: A sampled bit of the opposite value restarts the count at length one for the new polarity.
- R7: While `smp_en` is 0, the state holds, `flag_o` is 1 and `din` is ignored.
- R8: `state_o` encodes the state as follows: 0 is start; 1, 2 and 3 mean one, two or three zeros seen; 4 and 5 mean one or two ones seen. No other code ever appears on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Qualifies `din` for this cycle |
| din | input | 1 | Serial data bit |
| flag_o | output | 1 | High except in a cycle that completes a run |
| state_o | output | 3 | Current state code, for debug |

## Verification
The assertions assume that `rst`, `smp_en` and `din` are 0 or 1 at every rising edge and are stable around it, and that `rst` is asserted from time zero. The bench meets these conditions by changing all inputs only on the falling edge and by holding reset high from the first cycle. Run lengths are tracked with bench counters, and the expected flag and state are derived from those counts rather than from any copy of the state machine. The stimulus covers exact-threshold runs and long runs in both polarities, polarity switches just short of a threshold, gaps in the strobe inside a run, and a reset in the middle of a run.

// File: rtl/run_flag_fsm.sv
module run_flag_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp_en,
  input  logic       din,
  output logic       flag_o,
  output logic [2:0] state_o
);

  typedef enum logic [2:0] {
    S_START = 3'd0,
    S_Z1    = 3'd1,
    S_Z2    = 3'd2,
    S_Z3    = 3'd3,
    S_O1    = 3'd4,
    S_O2    = 3'd5
  } st_t;

  st_t st, st_nx;
  logic hit;

  always_comb begin
    st_nx = st;
    if (smp_en) begin
      unique case (st)
        S_START: st_nx = din ? S_O1 : S_Z1;
        S_Z1:    st_nx = din ? S_O1 : S_Z2;
        S_Z2:    st_nx = din ? S_O1 : S_Z3;
        S_Z3:    st_nx = din ? S_O1 : S_START;
        S_O1:    st_nx = din ? S_O2 : S_Z1;
        S_O2:    st_nx = din ? S_START : S_Z1;
        default: st_nx = S_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_START;
    else     st <= st_nx;
  end

  assign hit     = smp_en && !rst && ((st == S_Z3 && !din) || (st == S_O2 && din));
  assign flag_o  = !hit;
  assign state_o = st;

endmodule

module run_flag_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       smp_en,
  input logic       din,
  input logic       flag_o,
  input logic [2:0] state_o
);

  p_reset_start_r1: assert property (@(posedge clk) rst |=> state_o == 3'd0);
  p_reset_flag_r1:  assert property (@(posedge clk) rst |-> flag_o);

  p_low_only_on_run_r2: assert property (@(posedge clk) disable iff (rst)
    !flag_o |-> smp_en && ((state_o == 3'd3 && !din) || (state_o == 3'd5 && din)));

  p_zero_run_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_en && !din && state_o == 3'd3) |-> !flag_o);

  p_one_run_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_en && din && state_o == 3'd5) |-> !flag_o);

  p_restart_after_hit_r5: assert property (@(posedge clk) disable iff (rst)
    !flag_o |=> state_o == 3'd0);

  p_switch_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_en && din && state_o >= 3'd1 && state_o <= 3'd3) |=> state_o == 3'd4);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> state_o == $past(state_o));

  p_idle_flag_r7: assert property (@(posedge clk) disable iff (rst)
    !smp_en |-> flag_o);

  p_legal_code_r8: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd5);

endmodule

bind run_flag_fsm run_flag_fsm_chk u_chk (
  .clk(clk), .rst(rst), .smp_en(smp_en), .din(din),
  .flag_o(flag_o), .state_o(state_o)
);

// File: tb/run_flag_fsm_tb.sv
`timescale 1ns/1ps
module run_flag_fsm_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_en = 1'b0;
  logic       din = 1'b0;
  logic       flag_o;
  logic [2:0] state_o;

  always #2.5 clk = ~clk;

  run_flag_fsm u_dut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .din(din),
    .flag_o(flag_o), .state_o(state_o)
  );

  typedef struct {
    logic       flag;
    logic [2:0] st;
    string      tag;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  int zrun = 0;
  int orun = 0;
  bit done = 0;

  function automatic logic [2:0] code_of();
    if (zrun > 0) return 3'(zrun);
    if (orun > 0) return 3'(3 + orun);
    return 3'd0;
  endfunction

  task automatic apply(input logic r, input logic e, input logic d, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; smp_en = e; din = d;
    it.flag = 1'b1;
    if (r) begin
      zrun = 0; orun = 0;
    end else if (e) begin
      if (!d) begin
        orun = 0; zrun++;
        if (zrun == 4) begin it.flag = 1'b0; zrun = 0; end
      end else begin
        zrun = 0; orun++;
        if (orun == 3) begin it.flag = 1'b0; orun = 0; end
      end
    end
    it.st = code_of();
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic bits(input string pat, input string tag);
    for (int i = 0; i < pat.len(); i++)
      apply(1'b0, 1'b1, pat[i] == "1", tag);
  endtask

  initial begin
    forever begin
      item_t it;
      @(negedge clk);
      #1;
      if (q.size() != 0) begin
        it = q[0];
        n_vec++;
        if (flag_o !== it.flag) begin
          n_bad++;
          $display("FAIL %s flag_o actual=%b expected=%b", it.tag, flag_o, it.flag);
        end
        @(posedge clk);
        #1;
        if (state_o !== it.st) begin
          n_bad++;
          $display("FAIL %s/R8 state_o actual=%0d expected=%0d", it.tag, state_o, it.st);
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    apply(1'b1, 1'b0, 1'b0, "R1");
    apply(1'b1, 1'b1, 1'b0, "R1");
    apply(1'b1, 1'b1, 1'b1, "R1");
    bits("0000", "R3");
    bits("111", "R4");
    bits("000000000", "R5");
    bits("1111111", "R5");
    bits("0001", "R6");
    bits("110", "R6");
    bits("00011", "R6");
    bits("0111", "R6");
    bits("01010101", "R2");
    bits("00", "R7");
    apply(1'b0, 1'b0, 1'b0, "R7");
    apply(1'b0, 1'b0, 1'b1, "R7");
    apply(1'b0, 1'b0, 1'b0, "R7");
    bits("00", "R7");
    bits("1", "R7");
    apply(1'b0, 1'b0, 1'b1, "R7");
    apply(1'b0, 1'b0, 1'b1, "R7");
    bits("1", "R7");
    bits("1", "R7");
    bits("000", "R1");
    apply(1'b1, 1'b1, 1'b0, "R1");
    bits("000", "R1");
    bits("0", "R3");
    bits("11", "R1");
    apply(1'b1, 1'b1, 1'b1, "R1");
    bits("11", "R2");
    bits("1", "R4");
    apply(1'b0, 1'b0, 1'b0, "R7");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule